// File: doc/BRIEF.md
# Bayer Channel Black-Level and Gain Corrector

This block sits at the head of a camera pixel pipeline, before demosaicing. It accepts one 12-bit raw mosaic sample per clock, qualified by a valid flag and marked with start-of-frame and start-of-line flags. It tracks where each sample falls in an RGGB mosaic and applies that site's own correction. The correction removes a pedestal, clamps at zero, scales by an unsigned fixed-point gain and adds a lift. The result goes out three clocks later with its flags delayed to match.

Each of the four mosaic sites (red, green beside red, green beside blue, blue) has its own pedestal, gain and lift. The two greens are kept apart because they lie on rows of opposite parity. Settings come in through a plain single-cycle register write port. Writes are meant to be made between frames.

Top module: `bayer_gain_stage`

## Requirements
- R1: After reset every output is 0. Every lift is 1200, every gain is 1.0 (0x2000) and every pedestal is 0, so a sample p comes out as min(p + 1200, 4095).
- R2: Each sample's site code is {line parity, pixel parity}: 0 red, 1 green on a red row, 2 green on a blue row, 3 blue. Pixel parity alternates on every valid sample. A start-of-line sample is pixel 0 of the next line parity.
- R3: The pedestal is subtracted first. A difference below zero becomes 0 before the gain is applied.
- R4: The gain is unsigned with 3 integer and 13 fraction bits. The product is truncated by dropping its 13 fraction bits.
- R5: The lift is added after the gain, and any sum above 4095 is held at 4095.
- R6: Write word index = group * 4 + site. Group 0 holds lifts, group 1 gains and group 2 pedestals. Lifts and pedestals keep data bits 11:0 and gains keep bits 15:0. Indices 12 to 15 change nothing.
- R7: Corrected pixel, valid, start-of-line and start-of-frame appear exactly 3 clocks after the sample is presented.
- R8: A cycle without valid produces no output valid and no output flags. It does not advance the mosaic phase, and any flags it carries are ignored.
- R9: A valid start-of-frame sample is always site 0, even when start-of-line is also set, and the line after it counts as a blue row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Setting write strobe |
| cfgAddr | input | 4 | Setting word index |
| cfgWrData | input | 16 | Setting write data |
| inValid | input | 1 | Input sample qualifier |
| inSol | input | 1 | Input sample starts a line |
| inSof | input | 1 | Input sample starts a frame |
| inPix | input | 12 | Raw input sample |
| outValid | output | 1 | Output sample qualifier |
| outSol | output | 1 | Output sample starts a line |
| outSof | output | 1 | Output sample starts a frame |
| outPix | output | 12 | Corrected output sample |

## Verification
Each site gets a different lift. A design that mixed up the two greens, or kept row parity across a new frame, would then return another site's lift. Samples just below, at and just above the pedestal target the clamp: one that wrapped instead of clamping would give a huge value, and one that clamped after the gain would be off by a scaled amount. Fractional gains and the largest gain check truncation and the 4095 ceiling, where a design that rounded up or wrapped on overflow gives a visibly wrong pixel. Idle cycles that carry stray flags and writes to the unused indices must leave phase and settings untouched. Any leak shows up as a shifted site or a changed output.

// File: rtl/bgs_pkg.sv
`timescale 1ns/1ps
package bgs_pkg;
  localparam int PIX_W     = 12;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 13;
  localparam int NUM_CH    = 4;
  localparam int CH_W      = $clog2(NUM_CH);

  typedef enum logic [CH_W-1:0] {
    CH_RED   = 2'd0,
    CH_GRN_R = 2'd1,
    CH_GRN_B = 2'd2,
    CH_BLUE  = 2'd3
  } bayerCh_e;

  typedef enum logic [1:0] {
    GRP_OFFSET = 2'd0,
    GRP_GAIN   = 2'd1,
    GRP_BLACK  = 2'd2,
    GRP_NONE   = 2'd3
  } cfgGrp_e;

  // strobes handed from control to datapath with each sample
  typedef struct packed {
    logic     valid;
    logic     sol;
    logic     sof;
    bayerCh_e chan;
  } pixTag_t;

  typedef struct packed {
    logic [PIX_W-1:0]  black;
    logic [GAIN_W-1:0] gain;
    logic [PIX_W-1:0]  offset;
  } chanCfg_t;

  function automatic bayerCh_e siteOf(input logic lineOdd, input logic pixOdd);
    return bayerCh_e'({lineOdd, pixOdd});
  endfunction
endpackage

// File: rtl/bgs_ctrl.sv
`timescale 1ns/1ps
module bgs_ctrl
  import bgs_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter int                CHANNELS   = NUM_CH,
  parameter logic [PIX_W-1:0]  OFFSET_RST = 12'd1200,
  parameter logic [GAIN_W-1:0] GAIN_RST   = 16'h2000,
  parameter logic [PIX_W-1:0]  BLACK_RST  = 12'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [GAIN_W-1:0] cfgWrData,
  input  logic              inValid,
  input  logic              inSol,
  input  logic              inSof,
  input  logic [PIX_W-1:0]  inPix,
  output pixTag_t           tagOut,
  output logic [PIX_W-1:0]  pixOut,
  output chanCfg_t          cfgOut
);
  localparam int SEL_W = $clog2(CHANNELS);

  logic [PIX_W-1:0]  offsetQ [CHANNELS];
  logic [GAIN_W-1:0] gainQ   [CHANNELS];
  logic [PIX_W-1:0]  blackQ  [CHANNELS];

  cfgGrp_e           wrGrp;
  logic [SEL_W-1:0]  wrCh;
  logic [CHANNELS-1:0] hitOffset, hitGain, hitBlack;

  assign wrGrp = cfgGrp_e'(cfgAddr[ADDR_W-1:SEL_W]);
  assign wrCh  = cfgAddr[SEL_W-1:0];

  // one decode slice per mosaic site
  generate
    for (genvar g = 0; g < CHANNELS; g++) begin : g_dec
      assign hitOffset[g] = cfgWrEn && (wrGrp == GRP_OFFSET) && (wrCh == SEL_W'(g));
      assign hitGain[g]   = cfgWrEn && (wrGrp == GRP_GAIN)   && (wrCh == SEL_W'(g));
      assign hitBlack[g]  = cfgWrEn && (wrGrp == GRP_BLACK)  && (wrCh == SEL_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CHANNELS; i++) begin
        offsetQ[i] <= OFFSET_RST;
        gainQ[i]   <= GAIN_RST;
        blackQ[i]  <= BLACK_RST;
      end
    end else begin
      for (int i = 0; i < CHANNELS; i++) begin
        if (hitOffset[i]) offsetQ[i] <= cfgWrData[PIX_W-1:0];
        if (hitGain[i])   gainQ[i]   <= cfgWrData;
        if (hitBlack[i])  blackQ[i]  <= cfgWrData[PIX_W-1:0];
      end
    end
  end

  // mosaic phase of the sample now at the input
  logic lineOdd, pixOdd;
  logic curLine, curPix;

  always_comb begin
    if (inSof) begin
      curLine = 1'b0;
      curPix  = 1'b0;
    end else if (inSol) begin
      curLine = ~lineOdd;
      curPix  = 1'b0;
    end else begin
      curLine = lineOdd;
      curPix  = ~pixOdd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOdd <= 1'b0;
      pixOdd  <= 1'b1;
    end else if (inValid) begin
      lineOdd <= curLine;
      pixOdd  <= curPix;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagOut <= '0;
      pixOut <= '0;
    end else begin
      tagOut.valid <= inValid;
      tagOut.sol   <= inValid && inSol;
      tagOut.sof   <= inValid && inSof;
      tagOut.chan  <= siteOf(curLine, curPix);
      pixOut       <= inPix;
    end
  end

  always_comb begin
    cfgOut.black  = blackQ[tagOut.chan];
    cfgOut.gain   = gainQ[tagOut.chan];
    cfgOut.offset = offsetQ[tagOut.chan];
  end
endmodule

// File: rtl/bgs_datapath.sv
`timescale 1ns/1ps
module bgs_datapath
  import bgs_pkg::*;
#(
  parameter int SCALED_W = PIX_W + GAIN_W - GAIN_FRAC
) (
  input  logic             clk,
  input  logic             rstN,
  input  pixTag_t          tagIn,
  input  logic [PIX_W-1:0] pixIn,
  input  chanCfg_t         cfgIn,
  output logic             outValid,
  output logic             outSol,
  output logic             outSof,
  output logic [PIX_W-1:0] outPix
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int SUM_W  = SCALED_W + 1;
  localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [PIX_W:0]      diff;
  logic [PIX_W-1:0]    lifted;
  logic [PROD_W-1:0]   prod;
  logic [SCALED_W-1:0] scaled, scaledQ;
  logic [PIX_W-1:0]    offsetQ;
  pixTag_t             tagQ;
  logic [SUM_W-1:0]    sum;

  // stage 1: pedestal removal, clamp at zero, gain with truncation
  always_comb begin
    diff   = {1'b0, pixIn} - {1'b0, cfgIn.black};
    lifted = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
    prod   = PROD_W'(lifted) * PROD_W'(cfgIn.gain);
    scaled = prod[PROD_W-1:GAIN_FRAC];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaledQ <= '0;
      offsetQ <= '0;
      tagQ    <= '0;
    end else begin
      scaledQ <= scaled;
      offsetQ <= cfgIn.offset;
      tagQ    <= tagIn;
    end
  end

  // stage 2: lift and ceiling
  assign sum = SUM_W'(scaledQ) + SUM_W'(offsetQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      outSof   <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= tagQ.valid;
      outSol   <= tagQ.sol;
      outSof   <= tagQ.sof;
      outPix   <= (sum > PIX_MAX) ? '1 : sum[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/bayer_gain_stage.sv
`timescale 1ns/1ps
module bayer_gain_stage
  import bgs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [GAIN_W-1:0] cfgWrData,
  input  logic              inValid,
  input  logic              inSol,
  input  logic              inSof,
  input  logic [PIX_W-1:0]  inPix,
  output logic              outValid,
  output logic              outSol,
  output logic              outSof,
  output logic [PIX_W-1:0]  outPix
);
  pixTag_t          stageTag;
  logic [PIX_W-1:0] stagePix;
  chanCfg_t         stageCfg;

  bgs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .inValid(inValid), .inSol(inSol), .inSof(inSof), .inPix(inPix),
    .tagOut(stageTag), .pixOut(stagePix), .cfgOut(stageCfg)
  );

  bgs_datapath dp_i (
    .clk(clk), .rstN(rstN),
    .tagIn(stageTag), .pixIn(stagePix), .cfgIn(stageCfg),
    .outValid(outValid), .outSol(outSol), .outSof(outSof), .outPix(outPix)
  );
endmodule

// File: rtl/bgs_checker.sv
`timescale 1ns/1ps
module bgs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inSol,
  input logic       inSof,
  input logic       outValid,
  input logic       outSol,
  input logic       outSof,
  input logic       tagValid,
  input logic [1:0] tagChan,
  input logic       lineOdd,
  input logic       pixOdd
);
  logic [1:0] armCnt;
  logic       armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armCnt <= 2'd0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
  end
  assign armed = (armCnt == 2'd3);

  AST_LATENCY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outValid == $past(inValid, 3))); // R7
  AST_LATENCY_SOF: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outSof == $past(inValid && inSof, 3))); // R7
  AST_LATENCY_SOL: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (outSol == $past(inValid && inSol, 3))); // R7
  AST_QUIET_MARKERS: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outSol && !outSof)); // R8
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(lineOdd) && $stable(pixOdd))); // R8
  AST_SOF_RED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof) |=> (tagValid && tagChan == 2'd0)); // R9
  AST_SOL_NEXT_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSol && !inSof) |=> (!tagChan[0] && (tagChan[1] != $past(lineOdd)))); // R2
endmodule

bind bayer_gain_stage bgs_checker chk_i (
  .clk(clk), .rstN(rstN),
  .inValid(inValid), .inSol(inSol), .inSof(inSof),
  .outValid(outValid), .outSol(outSol), .outSof(outSof),
  .tagValid(stageTag.valid), .tagChan(stageTag.chan),
  .lineOdd(ctrl_i.lineOdd), .pixOdd(ctrl_i.pixOdd)
);

// File: tb/bayer_gain_stage_tb.sv
`timescale 1ns/1ps
module bayer_gain_stage_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        inValid = 1'b0, inSol = 1'b0, inSof = 1'b0;
  logic [11:0] inPix = '0;
  logic        outValid, outSol, outSof;
  logic [11:0] outPix;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // bench shadow of the settings
  int shOff [4] = '{1200, 1200, 1200, 1200};
  int shGain[4] = '{8192, 8192, 8192, 8192};
  int shBlk [4] = '{0, 0, 0, 0};

  // expectation delay line, latency 3
  bit    expV[3]   = '{0, 0, 0};
  bit    expSol[3] = '{0, 0, 0};
  bit    expSof[3] = '{0, 0, 0};
  int    expPix[3] = '{0, 0, 0};
  string expReq[3] = '{"R1", "R1", "R1"};

  always #2.5 clk = ~clk;

  bayer_gain_stage dut_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .inValid(inValid), .inSol(inSol), .inSof(inSof), .inPix(inPix),
    .outValid(outValid), .outSol(outSol), .outSof(outSof), .outPix(outPix)
  );

  function automatic int model(int pix, int ch);
    int d, p, s;
    d = (pix > shBlk[ch]) ? pix - shBlk[ch] : 0;
    p = (d * shGain[ch]) >>> 13;
    s = p + shOff[ch];
    return (s > 4095) ? 4095 : s;
  endfunction

  task automatic checkOut();
    bit ok;
    compared++;
    if (expV[2]) ok = outValid && (int'(outPix) == expPix[2]) && (outSol == expSol[2]) && (outSof == expSof[2]);
    else         ok = !outValid && !outSol && !outSof;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: v/sol/sof/pix actual %0b/%0b/%0b/%0d expected %0b/%0b/%0b/%0d",
               expReq[2], outValid, outSol, outSof, outPix,
               expV[2], expSol[2], expSof[2], expV[2] ? expPix[2] : 0);
    end
  endtask

  task automatic step(bit v, bit sol, bit sof, int pix, int ch,
                      bit wen, int widx, int wdata, string req);
    @(negedge clk);
    checkOut();
    for (int k = 2; k > 0; k--) begin
      expV[k] = expV[k-1]; expSol[k] = expSol[k-1]; expSof[k] = expSof[k-1];
      expPix[k] = expPix[k-1]; expReq[k] = expReq[k-1];
    end
    expV[0] = v; expSol[0] = v && sol; expSof[0] = v && sof;
    expPix[0] = v ? model(pix, ch) : 0; expReq[0] = req;
    inValid = v; inSol = sol; inSof = sof; inPix = 12'(pix);
    cfgWrEn = wen; cfgAddr = 4'(widx); cfgWrData = 16'(wdata);
    if (wen && widx < 12) begin
      if (widx < 4)      shOff[widx % 4]  = wdata & 12'hFFF;
      else if (widx < 8) shGain[widx % 4] = wdata & 16'hFFFF;
      else               shBlk[widx % 4]  = wdata & 12'hFFF;
    end
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic cfgWrite(int idx, int data, string req);
    step(0, 0, 0, 0, 0, 1, idx, data, req);
  endtask

  task automatic sendPix(int pix, bit sol, bit sof, int ch, string req);
    step(1, sol, sof, pix, ch, 0, 0, 0, req);
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compared++;
      if (outValid || outSol || outSof || outPix != 0) begin
        mismatched++;
        $display("FAIL R1: reset outputs actual %0b/%0b/%0b/%0d expected 0/0/0/0",
                 outValid, outSol, outSof, outPix);
      end
    end
    rstN = 1'b1;
    idle(2, "R1");
  endtask

  task automatic testDefaults();
    sendPix(0,    0, 1, 0, "R1");
    sendPix(100,  0, 0, 1, "R1");
    sendPix(2895, 0, 0, 0, "R5");
    sendPix(2896, 0, 0, 1, "R5");
    sendPix(5,    1, 0, 2, "R1");
    sendPix(6,    0, 0, 3, "R1");
    idle(3, "R7");
  endtask

  task automatic testChannelMap();
    cfgWrite(0, 10, "R6"); cfgWrite(1, 20, "R6");
    cfgWrite(2, 30, "R6"); cfgWrite(3, 40, "R6");
    idle(1, "R6");
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 4; c++)
        sendPix(r * 16 + c, (c == 0) && (r > 0), (r == 0) && (c == 0), (r % 2) * 2 + (c % 2), "R2");
    idle(3, "R2");
  endtask

  task automatic testGaps();
    sendPix(1, 0, 1, 0, "R8");
    step(0, 1, 1, 0, 0, 0, 0, 0, "R8");
    idle(2, "R8");
    sendPix(2, 0, 0, 1, "R8");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R8");
    sendPix(3, 0, 0, 0, "R8");
    idle(3, "R8");
  endtask

  task automatic testSofPrecedence();
    sendPix(0, 0, 1, 0, "R9");
    sendPix(0, 0, 0, 1, "R9");
    sendPix(0, 1, 0, 2, "R9");
    sendPix(0, 0, 0, 3, "R9");
    sendPix(0, 1, 1, 0, "R9");
    sendPix(0, 0, 0, 1, "R9");
    sendPix(0, 1, 0, 2, "R9");
    sendPix(0, 1, 0, 0, "R2");
    idle(3, "R9");
  endtask

  task automatic testBlackClamp();
    cfgWrite(8, 16'hF1F4, "R6");
    cfgWrite(0, 7, "R3");
    idle(1, "R3");
    sendPix(400,  0, 1, 0, "R3");
    sendPix(500,  0, 1, 0, "R3");
    sendPix(501,  0, 1, 0, "R3");
    sendPix(0,    0, 1, 0, "R3");
    sendPix(4095, 0, 1, 0, "R3");
    idle(3, "R3");
  endtask

  task automatic testGain();
    cfgWrite(8, 0, "R4"); cfgWrite(0, 0, "R4"); cfgWrite(4, 16'h3000, "R4");
    idle(1, "R4");
    sendPix(3,    0, 1, 0, "R4");
    sendPix(4095, 0, 1, 0, "R5");
    idle(3, "R4");
    cfgWrite(4, 16'h1000, "R4"); idle(1, "R4");
    sendPix(7, 0, 1, 0, "R4");
    idle(3, "R4");
    cfgWrite(4, 16'hFFFF, "R4"); idle(1, "R4");
    sendPix(1,    0, 1, 0, "R4");
    sendPix(4095, 0, 1, 0, "R5");
    idle(3, "R5");
    cfgWrite(4, 0, "R5"); cfgWrite(0, 4095, "R5"); idle(1, "R5");
    sendPix(4095, 0, 1, 0, "R5");
    idle(3, "R5");
  endtask

  task automatic testIgnoredAddr();
    for (int a = 12; a < 16; a++) cfgWrite(a, 16'hFFFF, "R6");
    idle(1, "R6");
    sendPix(9, 0, 1, 0, "R6");
    sendPix(9, 0, 0, 1, "R6");
    sendPix(9, 1, 0, 2, "R6");
    sendPix(9, 0, 0, 3, "R6");
    idle(3, "R6");
  endtask

  task automatic testLatency();
    idle(2, "R7");
    sendPix(77, 1, 1, 0, "R7");
    idle(2, "R7");
    sendPix(78, 0, 0, 1, "R7");
    sendPix(79, 1, 0, 2, "R7");
    idle(4, "R7");
  endtask

  initial begin
    testReset();
    testDefaults();
    testChannelMap();
    testGaps();
    testSofPrecedence();
    testBlackClamp();
    testGain();
    testIgnoredAddr();
    testLatency();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule